// File: doc/BRIEF.md
# Operand Address Generator

This unit forms the operand address of an 8-bit processor that sees one flat 64 KB space of 16-bit addresses. Every cycle in which the sequencer marks a request valid, the unit takes an addressing-mode code, up to two operand bytes, the program counter, the 16-bit index pair (high and low index bytes together) and the 16-bit stack pointer. One clock later it presents the effective address and a flag that says whether the instruction reaches memory at all. For the two post-increment index submodes it also presents the incremented index value with a one-cycle write strobe.

The arithmetic is split into two sources. A flat source covers the modes that need only the program counter and the operand bytes. An indexed source covers the five index-pair submodes and the two stack-relative forms. A single output register stage merges the two sources. Opcode decode, bus sequencing, the data path and memory-to-memory moves belong to other blocks.

Top module: `ea_addr_gen`

## Requirements
- R1: While reset is held and after it is released, with no request made, `out_valid`, `ea`, `mem_req`, `hx_we` and `hx_next` are all zero.
- R2: A request with `in_valid` high at a rising edge yields `out_valid` high after that edge. With no request, `out_valid`, `mem_req` and `hx_we` are low after the edge.
- R3: Mode 2 (direct page) gives `ea` = {8'h00, op_lo}.
- R4: Mode 3 (extended) gives `ea` = {op_hi, op_lo}.
- R5: Mode 4 (branch relative) gives `ea` = pc + sign-extended op_lo, modulo 2^16.
- R6: Mode 1 (immediate) gives `ea` = pc.
- R7: Mode 0 (inherent) and the unused codes 12 to 15 give `mem_req` = 0, `hx_we` = 0 and `ea` = 0.
- R8: The non-incrementing index submodes give `ea` = hx (mode 5), hx + zero-extended op_lo (mode 7) and hx + {op_hi, op_lo} (mode 9), each modulo 2^16.
- R9: The post-increment submodes give `ea` = hx (mode 6) and hx + zero-extended op_lo (mode 8), both using the index value before the increment. Each such request raises `hx_we` for exactly one cycle, with `hx_next` = hx + 1 modulo 2^16.
- R10: For every mode other than 6 and 8, `hx_we` stays low and `hx_next` returns hx unchanged.
- R11: Stack-relative modes give `ea` = sp + zero-extended op_lo (mode 10) and sp + {op_hi, op_lo} (mode 11), modulo 2^16.
- R12: `mem_req` is high for a valid response in modes 1 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing-mode code (see requirements) |
| op_hi | input | 8 | High operand byte |
| op_lo | input | 8 | Low operand byte, or an 8-bit offset |
| pc | input | 16 | Program counter |
| hx | input | 16 | Index pair |
| sp | input | 16 | Stack pointer |
| out_valid | output | 1 | Response present |
| ea | output | 16 | Effective address |
| mem_req | output | 1 | Instruction needs a memory access |
| hx_next | output | 16 | Index value to write back |
| hx_we | output | 1 | Index write strobe |

## Verification
Every one of the sixteen mode codes is driven with all 256 low-byte values. Each code is paired with high bytes 00, 80 and FF and with base values 0000, 00FF, 7FFF and FFFF, each base sent to the program counter, the index pair and the stack pointer in a different form. The sign boundary of the low byte tells sign extension (mode 4) apart from zero extension (modes 7, 8 and 10). The all-ones bases show whether every sum wraps at 2^16, including the increment of the index pair. Idle cycles placed after some requests show that the write strobe falls after one cycle, and the unused codes show that they stay silent.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_INH   = 4'd0,
    AM_IMM   = 4'd1,
    AM_DIR   = 4'd2,
    AM_EXT   = 4'd3,
    AM_REL   = 4'd4,
    AM_IX0   = 4'd5,
    AM_IX0P  = 4'd6,
    AM_IX8   = 4'd7,
    AM_IX8P  = 4'd8,
    AM_IX16  = 4'd9,
    AM_SP8   = 4'd10,
    AM_SP16  = 4'd11
  } am_mode_e;
endpackage

// File: rtl/ea_flat_unit.sv
module ea_flat_unit #(
  parameter int BYTE_W = 8
) (
  input  logic [3:0]          mode,
  input  logic [BYTE_W-1:0]   op_hi,
  input  logic [BYTE_W-1:0]   op_lo,
  input  logic [2*BYTE_W-1:0] pc,
  output logic [2*BYTE_W-1:0] addr,
  output logic                hit
);
  import ea_pkg::*;
  localparam int ADDR_W = 2 * BYTE_W;

  function automatic logic [ADDR_W-1:0] sext_off(input logic [BYTE_W-1:0] b);
    return {{BYTE_W{b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [ADDR_W-1:0] page0(input logic [BYTE_W-1:0] b);
    return {{BYTE_W{1'b0}}, b};
  endfunction

  always_comb begin
    addr = '0;
    hit  = 1'b1;
    case (mode)
      AM_IMM:  addr = pc;
      AM_DIR:  addr = page0(op_lo);
      AM_EXT:  addr = {op_hi, op_lo};
      AM_REL:  addr = pc + sext_off(op_lo);
      default: hit  = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_index_unit.sv
module ea_index_unit #(
  parameter int BYTE_W = 8
) (
  input  logic [3:0]          mode,
  input  logic [BYTE_W-1:0]   op_hi,
  input  logic [BYTE_W-1:0]   op_lo,
  input  logic [2*BYTE_W-1:0] hx,
  input  logic [2*BYTE_W-1:0] sp,
  output logic [2*BYTE_W-1:0] addr,
  output logic                hit,
  output logic                post,
  output logic [2*BYTE_W-1:0] hx_inc
);
  import ea_pkg::*;
  localparam int ADDR_W = 2 * BYTE_W;

  function automatic logic [ADDR_W-1:0] zext_off(input logic [BYTE_W-1:0] b);
    return {{BYTE_W{1'b0}}, b};
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] off);
    return base + off;
  endfunction

  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] off_sel;

  always_comb begin
    base_sel = hx;
    off_sel  = '0;
    hit      = 1'b1;
    post     = 1'b0;
    case (mode)
      AM_IX0:  ;
      AM_IX0P: post = 1'b1;
      AM_IX8:  off_sel = zext_off(op_lo);
      AM_IX8P: begin off_sel = zext_off(op_lo); post = 1'b1; end
      AM_IX16: off_sel = {op_hi, op_lo};
      AM_SP8:  begin base_sel = sp; off_sel = zext_off(op_lo); end
      AM_SP16: begin base_sel = sp; off_sel = {op_hi, op_lo}; end
      default: hit = 1'b0;
    endcase
  end

  assign addr   = hit ? wrap_add(base_sel, off_sel) : '0;
  assign hx_inc = wrap_add(hx, {{(ADDR_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0]          mode,
  input  logic [BYTE_W-1:0]   op_hi,
  input  logic [BYTE_W-1:0]   op_lo,
  input  logic [2*BYTE_W-1:0] pc,
  input  logic [2*BYTE_W-1:0] hx,
  input  logic [2*BYTE_W-1:0] sp,
  output logic                out_valid,
  output logic [2*BYTE_W-1:0] ea,
  output logic                mem_req,
  output logic [2*BYTE_W-1:0] hx_next,
  output logic                hx_we
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] flat_addr;
  logic              flat_hit;
  logic [ADDR_W-1:0] idx_addr;
  logic              idx_hit;
  logic              post_evt;
  logic [ADDR_W-1:0] hx_inc;
  logic [ADDR_W-1:0] sel_addr;
  logic              access;

  ea_flat_unit #(.BYTE_W(BYTE_W)) u_flat (
    .mode(mode), .op_hi(op_hi), .op_lo(op_lo), .pc(pc),
    .addr(flat_addr), .hit(flat_hit)
  );

  ea_index_unit #(.BYTE_W(BYTE_W)) u_index (
    .mode(mode), .op_hi(op_hi), .op_lo(op_lo), .hx(hx), .sp(sp),
    .addr(idx_addr), .hit(idx_hit), .post(post_evt), .hx_inc(hx_inc)
  );

  assign access   = flat_hit | idx_hit;
  assign sel_addr = flat_hit ? flat_addr : (idx_hit ? idx_addr : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      mem_req   <= 1'b0;
      hx_next   <= '0;
      hx_we     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea      <= sel_addr;
        mem_req <= access;
        hx_we   <= post_evt;
        hx_next <= post_evt ? hx_inc : hx;
      end else begin
        mem_req <= 1'b0;
        hx_we   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ea_addr_gen_chk.sv
module ea_addr_gen_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [3:0]          mode,
  input logic [BYTE_W-1:0]   op_hi,
  input logic [BYTE_W-1:0]   op_lo,
  input logic [2*BYTE_W-1:0] hx,
  input logic                out_valid,
  input logic [2*BYTE_W-1:0] ea,
  input logic                mem_req,
  input logic [2*BYTE_W-1:0] hx_next,
  input logic                hx_we,
  input logic                flat_hit,
  input logic                idx_hit,
  input logic                post_evt
);
  localparam int ADDR_W = 2 * BYTE_W;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!mem_req && !hx_we)); // R2
  AST_DIRECT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 4'd2) |=> (ea[ADDR_W-1:BYTE_W] == '0)); // R3
  AST_EXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 4'd3) |=> (ea == {$past(op_hi), $past(op_lo)})); // R4
  AST_INH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 4'd0 || mode >= 4'd12)) |=> (!mem_req && !hx_we)); // R7
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && post_evt) |=> (hx_we && hx_next == $past(hx) + 1'b1)); // R9
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hx_we && !in_valid) |=> !hx_we); // R9
  AST_NO_STRAY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 4'd6 && mode != 4'd8) |=> !hx_we); // R10
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flat_hit && idx_hit)); // R12
  AST_ACCESS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode >= 4'd1 && mode <= 4'd11) |=> mem_req); // R12
endmodule

bind ea_addr_gen ea_addr_gen_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .op_hi(op_hi), .op_lo(op_lo), .hx(hx),
  .out_valid(out_valid), .ea(ea), .mem_req(mem_req),
  .hx_next(hx_next), .hx_we(hx_we),
  .flat_hit(flat_hit), .idx_hit(idx_hit), .post_evt(post_evt)
);

// File: tb/ea_addr_gen_tb.sv
`timescale 1ns/1ps
module ea_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_hi = '0;
  logic [7:0]  op_lo = '0;
  logic [15:0] pc = '0;
  logic [15:0] hx = '0;
  logic [15:0] sp = '0;
  logic        out_valid;
  logic [15:0] ea;
  logic        mem_req;
  logic [15:0] hx_next;
  logic        hx_we;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ea_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_hi(op_hi), .op_lo(op_lo), .pc(pc), .hx(hx), .sp(sp),
    .out_valid(out_valid), .ea(ea), .mem_req(mem_req),
    .hx_next(hx_next), .hx_we(hx_we)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R6";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5, 7, 9: return "R8";
      6, 8: return "R9";
      10, 11: return "R11";
      default: return "R7";
    endcase
  endfunction

  function automatic int model_ea(input int m, input int hi, input int lo,
                                 input int p, input int x, input int s);
    int signed_lo;
    int word;
    signed_lo = (lo >= 128) ? lo - 256 : lo;
    word = hi * 256 + lo;
    case (m)
      1: return p;
      2: return lo;
      3: return word;
      4: return (p + signed_lo + 65536) % 65536;
      5, 6: return x;
      7, 8: return (x + lo) % 65536;
      9: return (x + word) % 65536;
      10: return (s + lo) % 65536;
      11: return (s + word) % 65536;
      default: return 0;
    endcase
  endfunction

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int bases [4] = '{32'h0000, 32'h00FF, 32'h7FFF, 32'hFFFF};
    int his [3] = '{32'h00, 32'h80, 32'hFF};
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "ea in reset", int'(ea), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "mem_req after reset", int'(mem_req), 0);
    check("R1", "hx_we after reset", int'(hx_we), 0);
    check("R1", "hx_next after reset", int'(hx_next), 0);
    check("R1", "ea after reset", int'(ea), 0);

    for (int m = 0; m < 16; m++) begin
      for (int bi = 0; bi < 4; bi++) begin
        for (int hj = 0; hj < 3; hj++) begin
          for (int lo = 0; lo < 256; lo++) begin
            int p, x, s, exp_ea, exp_hxn;
            bit post, acc;
            p = bases[bi];
            x = (bases[bi] ^ 32'h5A5A) & 32'hFFFF;
            if (bi == 3) x = 32'hFFFF;
            s = 32'hFFFF - bases[bi];
            in_valid = 1'b1;
            mode = 4'(m);
            op_hi = 8'(his[hj]);
            op_lo = 8'(lo);
            pc = 16'(p);
            hx = 16'(x);
            sp = 16'(s);
            @(negedge clk);
            post = (m == 6 || m == 8);
            acc = (m >= 1 && m <= 11);
            exp_ea = model_ea(m, his[hj], lo, p, x, s);
            exp_hxn = post ? (x + 1) % 65536 : x;
            check("R2", "out_valid", int'(out_valid), 1);
            check(mode_tag(m), "ea", int'(ea), exp_ea);
            check(acc ? "R12" : "R7", "mem_req", int'(mem_req), int'(acc));
            check(post ? "R9" : "R10", "hx_we", int'(hx_we), int'(post));
            check(post ? "R9" : "R10", "hx_next", int'(hx_next), exp_hxn);
            if (lo == 0 || lo == 255) begin
              in_valid = 1'b0;
              @(negedge clk);
              check("R2", "idle out_valid", int'(out_valid), 0);
              check("R2", "idle mem_req", int'(mem_req), 0);
              check(post ? "R9" : "R10", "idle hx_we", int'(hx_we), 0);
            end
          end
        end
      end
    end

    in_valid = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule